// File: doc/BRIEF.md
# Routed Level-Interrupt Controller

This block collects nine level-sensitive interrupt inputs and forwards them to three interrupt request outputs toward a host processor. Each input first passes through a polarity stage that turns it into an active-high "asserted" level. Three of the inputs have a fixed polarity. The other six are set by a polarity register. Each output owns one 32-bit register. The low half of that register holds a per-source enable field and the upper half holds a per-source pending field. Software routes a source to an output by setting that source's enable bit in exactly one output register.

While a normalised source level is asserted and enabled in an output register, its pending flag in that register is set, and it then stays set until software acknowledges it. An acknowledge is a register write with a one in the pending bit position. The same write loads a fresh enable field. Each request output is a registered OR of its pending field.

Software reaches the registers through a plain 32-bit port. The port uses word addresses, takes writes in one cycle and returns reads from a register. Word address 0 is the polarity register and word address 1+n belongs to output n, so the byte offsets are 4 times the word address.

Top module: `lirq_router`

## Requirements
- R1: On a synchronous reset, every enable and pending bit is cleared, the configurable polarity bits are cleared, `irq_o` is 0 and `rd_data_o` is 0.
- R2: Word address 0 selects the polarity register, with bit k for source k in bits 8..0. Word address 1+n (n = 0..2) selects output n's register, with enables in bits 8..0 and pending flags in bits 24..16 (bit 16+k for source k).
- R3: A polarity bit of 1 means active-high and 0 means active-low. Sources 1 and 8 always read 1 and source 2 always reads 0, whatever is written to those bits.
- R4: At a clock edge where source k's normalised level is asserted and enable k of output n's register (its value before that edge) is 1, pending k of that register becomes 1.
- R5: A set pending flag stays set when its source deasserts or its enable is cleared, until a write-one acknowledge.
- R6: A write to output n's register with 1 in bit 16+k clears pending k at that edge, and 0 there leaves it unchanged. The same write loads bits 8..0 as the new enables. If the source is still asserted and enabled, the flag sets again at the next edge.
- R7: `irq_o[n]` is 1 exactly one cycle after any pending bit of output n's register is 1, and 0 one cycle after all are 0.
- R8: A source enabled in only one output register sets pending only in that register and drives only that request output.
- R9: Bits 15..9 and 31..25 of the output registers and bits 31..9 of the polarity register read as 0, and writes to them have no effect.
- R10: When `rd_en_i` is high at an edge, `rd_data_o` takes the addressed register's contents from before that edge, including when a write happens in the same cycle. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_i | input | 9 | Raw interrupt source levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Word address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 3 | Interrupt request outputs, active high |

## Verification
Pending flags change at the same edge that samples a source or a write. A request output follows one edge later, and read data becomes visible at the edge that samples `rd_en_i`. The bench keeps a behavioural model that advances by one clock per step, using the inputs applied before that edge. It compares `irq_o` and `rd_data_o` 2 ns after every rising edge, so each result is checked in the cycle it is due. Directed reads with hand-computed constants cover the polarity quirks, the reserved bits and a same-cycle read and write.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int SRC_CNT  = 9;
  localparam int OUT_CNT  = 3;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2;
  localparam int PEND_LSB = 16;
  localparam logic [SRC_CNT-1:0] FIXED_MASK = 9'b1_0000_0110;
  localparam logic [SRC_CNT-1:0] FIXED_HIGH = 9'b1_0000_0010;

  typedef struct packed {
    logic               polWr;
    logic [OUT_CNT-1:0] outWr;
    logic               rdStb;
    logic [ADDR_W-1:0]  rdSel;
    logic [REG_W-1:0]   wrData;
  } lirq_strobe_t;
endpackage

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
  import lirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output lirq_strobe_t      stb
);
  always_comb begin
    stb        = '0;
    stb.polWr  = wrEn && (addr == '0);
    for (int n = 0; n < OUT_CNT; n++) begin
      stb.outWr[n] = wrEn && (addr == ADDR_W'(n + 1));
    end
    stb.rdStb  = rdEn;
    stb.rdSel  = addr;
    stb.wrData = wrData;
  end

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({stb.polWr, stb.outWr})) else $error("write hits more than one register"); // R2
endmodule

// File: rtl/lirq_datapath.sv
module lirq_datapath
  import lirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [SRC_CNT-1:0] srcLvl,
  input  lirq_strobe_t       stb,
  output logic [REG_W-1:0]   rdData,
  output logic [OUT_CNT-1:0] irqOut
);
  localparam int PEND_MSB = PEND_LSB + SRC_CNT - 1;

  logic [SRC_CNT-1:0] polReg;
  logic [SRC_CNT-1:0] polEff;
  logic [SRC_CNT-1:0] actLvl;
  logic [OUT_CNT-1:0][SRC_CNT-1:0] enReg;
  logic [OUT_CNT-1:0][SRC_CNT-1:0] pendReg;
  logic [REG_W-1:0] rdMux;

  assign polEff = (polReg & ~FIXED_MASK) | (FIXED_HIGH & FIXED_MASK);
  assign actLvl = srcLvl ^ ~polEff;

  always_ff @(posedge clk_i) begin
    if (rst_i)            polReg <= '0;
    else if (stb.polWr)   polReg <= stb.wrData[SRC_CNT-1:0] & ~FIXED_MASK;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      enReg   <= '0;
      pendReg <= '0;
      irqOut  <= '0;
    end else begin
      for (int n = 0; n < OUT_CNT; n++) begin
        irqOut[n] <= |pendReg[n];
        if (stb.outWr[n]) begin
          enReg[n]   <= stb.wrData[SRC_CNT-1:0];
          pendReg[n] <= (pendReg[n] | (actLvl & enReg[n])) & ~stb.wrData[PEND_MSB:PEND_LSB];
        end else begin
          pendReg[n] <= pendReg[n] | (actLvl & enReg[n]);
        end
      end
    end
  end

  always_comb begin
    rdMux = '0;
    if (stb.rdSel == '0) rdMux[SRC_CNT-1:0] = polEff;
    for (int n = 0; n < OUT_CNT; n++) begin
      if (stb.rdSel == ADDR_W'(n + 1)) begin
        rdMux[SRC_CNT-1:0]       = enReg[n];
        rdMux[PEND_MSB:PEND_LSB] = pendReg[n];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)          rdData <= '0;
    else if (stb.rdStb) rdData <= rdMux;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    stb.rdStb |=> (rdData[PEND_LSB-1:SRC_CNT] == '0 && rdData[REG_W-1:PEND_MSB+1] == '0))
    else $error("reserved bits nonzero"); // R9

  for (genvar n = 0; n < OUT_CNT; n++) begin : g_chk_out
    for (genvar k = 0; k < SRC_CNT; k++) begin : g_chk_src
      AST_PEND_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pendReg[n][k]) |-> $past(actLvl[k] && enReg[n][k]))
        else $error("pending set without enabled level"); // R4
      AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb.outWr[n] && stb.wrData[PEND_LSB+k]) |=> !pendReg[n][k])
        else $error("acknowledge did not clear"); // R6
      AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (pendReg[n][k] && !(stb.outWr[n] && stb.wrData[PEND_LSB+k])) |=> pendReg[n][k])
        else $error("pending dropped without acknowledge"); // R5
    end
  end
endmodule

// File: rtl/lirq_router.sv
module lirq_router
  import lirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [SRC_CNT-1:0] src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic [OUT_CNT-1:0] irq_o
);
  lirq_strobe_t stb;

  lirq_ctrl ctrl_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .wrEn  (wr_en_i),
    .rdEn  (rd_en_i),
    .addr  (addr_i),
    .wrData(wr_data_i),
    .stb   (stb)
  );

  lirq_datapath dp_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .srcLvl(src_i),
    .stb   (stb),
    .rdData(rd_data_o),
    .irqOut(irq_o)
  );
endmodule

// File: tb/lirq_router_tb.sv
module lirq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  src = 9'h0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wd = 32'h0;
  logic [31:0] rdData;
  logic [2:0]  irq;

  int testsRun = 0, testsFailed = 0;
  bit done = 0;
  string curTag = "R1";

  localparam logic [8:0] FM = 9'h106;
  localparam logic [8:0] FH = 9'h102;

  logic [8:0]  mPol;
  logic [8:0]  mEn [3];
  logic [8:0]  mPend [3];
  logic [2:0]  mIrq;
  logic [31:0] mRd;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  lirq_router dut_i (
    .clk_i(clk), .rst_i(rst), .src_i(src), .wr_en_i(wrEn), .rd_en_i(rdEn),
    .addr_i(addr), .wr_data_i(wd), .rd_data_o(rdData), .irq_o(irq)
  );

  function automatic logic [8:0] effPol();
    return (mPol & ~FM) | (FH & FM);
  endfunction

  function automatic logic [31:0] regView(input logic [1:0] a);
    if (a == 2'd0) return {23'h0, effPol()};
    return {7'h0, mPend[a-1], 7'h0, mEn[a-1]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    logic [8:0]  act;
    logic [8:0]  nPend [3];
    logic [8:0]  nEn [3];
    logic [2:0]  nIrq;
    logic [31:0] nRd;
    logic [8:0]  nPol;
    act  = (src ^ ~effPol()) & 9'h1FF;
    nPol = mPol; nRd = mRd;
    for (int n = 0; n < 3; n++) begin
      nIrq[n]  = (mPend[n] != 0);
      nEn[n]   = mEn[n];
      nPend[n] = mPend[n] | (act & mEn[n]);
      if (wrEn && addr == 2'(n + 1)) begin
        nEn[n]   = wd[8:0];
        nPend[n] = nPend[n] & ~wd[24:16];
      end
    end
    if (wrEn && addr == 2'd0) nPol = wd[8:0] & ~FM;
    if (rdEn) nRd = regView(addr);
    @(posedge clk);
    #2;
    if (rst) begin
      mPol = 0; mIrq = 0; mRd = 0;
      for (int n = 0; n < 3; n++) begin mEn[n] = 0; mPend[n] = 0; end
    end else begin
      mPol = nPol; mIrq = nIrq; mRd = nRd;
      for (int n = 0; n < 3; n++) begin mEn[n] = nEn[n]; mPend[n] = nPend[n]; end
    end
    chk({curTag, " irq"}, {29'h0, irq}, {29'h0, mIrq});
    chk({curTag, " rdata"}, rdData, mRd);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1; addr = a; wd = d; step(); wrEn = 0;
  endtask

  task automatic rdReg(input logic [1:0] a);
    rdEn = 1; addr = a; step(); rdEn = 0;
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) step();
  endtask

  initial begin
    curTag = "R1";
    step(); step();
    rst = 0;
    chk("R1 irq after reset", {29'h0, irq}, 32'h0);
    chk("R1 rdata after reset", rdData, 32'h0);
    rdReg(2'd1); chk("R1 out0 reg", rdData, 32'h0);
    rdReg(2'd0); chk("R3 pol reset view", rdData, 32'h0000_0102);

    curTag = "R3";
    wrReg(2'd0, 32'hFFFF_FFFF);
    rdReg(2'd0); chk("R3 pol all ones", rdData, 32'h0000_01FB);
    wrReg(2'd0, 32'h0);
    rdReg(2'd0); chk("R3 pol zeros", rdData, 32'h0000_0102);

    src = 9'h0FD;
    curTag = "R4";
    wrReg(2'd1, 32'h0000_0001);
    idle(2);
    chk("R4 no pending while idle", {29'h0, irq}, 32'h0);
    src = 9'h0FC;
    idle(3);
    chk("R7 irq0 raised", {29'h0, irq}, 32'h1);
    rdReg(2'd1); chk("R4 pending bit16", rdData, 32'h0001_0001);

    curTag = "R5";
    src = 9'h0FD;
    wrReg(2'd1, 32'h0000_0000);
    idle(2);
    rdReg(2'd1); chk("R5 pending kept", rdData, 32'h0001_0000);

    curTag = "R6";
    wrReg(2'd1, 32'h0001_0001);
    idle(2);
    rdReg(2'd1); chk("R6 cleared, enable loaded", rdData, 32'h0000_0001);
    src = 9'h0FC;
    wrReg(2'd1, 32'h0001_0001);
    step();
    rdReg(2'd1); chk("R6 re-set while active", rdData, 32'h0001_0001);
    src = 9'h0FD;
    wrReg(2'd1, 32'h0001_0000);
    idle(2);
    chk("R7 irq0 dropped", {29'h0, irq}, 32'h0);

    curTag = "R8";
    wrReg(2'd0, 32'h0000_0020);
    src = 9'h0DD;
    wrReg(2'd3, 32'h0000_0020);
    src = 9'h0FD;
    idle(3);
    chk("R8 only irq2", {29'h0, irq}, 32'h4);
    rdReg(2'd2); chk("R8 out1 untouched", rdData, 32'h0000_0000);
    wrReg(2'd3, 32'h0020_0000);

    curTag = "R9";
    wrReg(2'd2, 32'hFE00_FE00);
    rdReg(2'd2); chk("R9 reserved read zero", rdData, 32'h0000_0000);

    curTag = "R10";
    rdEn = 1; wrEn = 1; addr = 2'd2; wd = 32'h0000_0003;
    step(); rdEn = 0; wrEn = 0;
    chk("R10 pre-write value", rdData, 32'h0000_0000);
    idle(2);
    chk("R10 holds", rdData, 32'h0000_0000);

    curTag = "R7";
    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      src  = lfsr[8:0];
      wrEn = (lfsr[12:10] == 3'd0);
      rdEn = lfsr[13];
      addr = lfsr[15:14];
      wd   = {lfsr[31:16], lfsr[31:16]} ^ {lfsr[15:0], 16'h0};
      step();
    end
    wrEn = 0; rdEn = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule